// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block merges two sources of interrupt requests into one pending priority level. The sources are a vector of software request bits and a vector of external status lines. It also forms a summary mask of every pending source. The merged level is compared with the core's current priority level. An interrupt request is raised only when the merged level is nonzero and strictly higher than the current level, and only while the two low bits of the program counter are clear.

When the core takes the interrupt, it pulses `take`. The block then holds the level and the mask that were resolved in that cycle, together with a valid flag. When the core later pulses `ack`, the held values are copied into an interrupt ID register and an interrupt summary register, and the valid flag clears. An `ack` that finds nothing held is flagged on `err`. A pending asynchronous trap request is also flagged on `err`, because this block does not handle it.

Software bits 1 to 15 map to levels 1 to 15. External lines 16 to 31 map to levels 16 to 31, and any external line outranks every software bit. Bits outside these two ranges are ignored.

Top module: `ipl_eval`

## Requirements
- R1: After reset, `int_id` and `int_sum` are zero and nothing is held, so an `ack` in the first cycle after reset raises `err`.
- R2: The resolved level from software is the highest index i in 1..15 with `sw_req[i]` set, and the level equals i. `sw_req[0]` and `sw_req[31:16]` have no effect on the level, the mask or `irq`.
- R3: If any `ext_stat[i]` with i in 16..31 is set, the resolved level is the highest such i, whatever software bits are set. `ext_stat[15:0]` has no effect.
- R4: The summary mask has bit i set exactly when i is in 1..15 and `sw_req[i]` is set, or when i is in 16..31 and `ext_stat[i]` is set.
- R5: `irq` is high only when the resolved level is nonzero and strictly greater than `cur_ipl`. An equal level gives no request.
- R6: `irq` is low in any cycle in which `pc_low` is not 2'b00. This output is combinational, in the same cycle as the inputs.
- R7: `take` while `irq` is high captures the resolved level and mask into the held state. `int_id` and `int_sum` change only on an `ack`.
- R8: An `ack` while held state is valid loads the held level into `int_id` and the held mask into `int_sum` on that clock edge, and clears the valid flag. A second `ack` then raises `err` and leaves both registers unchanged.
- R9: `err` is high, combinationally, in a cycle with `ack` high and no valid held state.
- R10: `err` is high, combinationally, in any cycle with `async_trap_req` high.
- R11: When `take` (with `irq` high) and `ack` fall in the same cycle, the commit uses the previously held values and the new values stay held as valid.
- R12: A `take` while `irq` is low captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 32 | Software request bits |
| ext_stat | input | 32 | External interrupt status lines |
| cur_ipl | input | 5 | Current priority level of the core |
| pc_low | input | 2 | Two low bits of the program counter |
| take | input | 1 | Core takes the interrupt now |
| ack | input | 1 | Commit held info to ID and summary registers |
| async_trap_req | input | 1 | Asynchronous trap request pending (unsupported) |
| irq | output | 1 | Interrupt request |
| int_id | output | 5 | Interrupt ID register (committed level) |
| int_sum | output | 32 | Interrupt summary register (committed mask) |
| err | output | 1 | Protocol or unsupported-request error |

## Verification
The capture of a new level by `take` and the commit of the old one by `ack` can fall on the same clock edge. The bench provokes this by taking a new, different interrupt while an earlier capture is still held and acknowledging in that same cycle. It then checks that the registers show the earlier values, and that a following `ack` alone brings in the newer ones. The bench also pairs `take` with an `ack` when nothing is held, to judge that `err` and a fresh capture coexist.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  // Bit mask with ones at indices lo..hi-1, returned at maximum width.
  function automatic logic [63:0] range_mask(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++)
      if (i >= lo && i < hi) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ipl_resolve.sv
module ipl_resolve #(
  parameter int VEC_W = 32,
  parameter int SW_LO = 1,
  parameter int SW_HI = 16,
  parameter int EX_LO = 16,
  parameter int EX_HI = 32,
  parameter int IPL_W = 5
) (
  input  logic [VEC_W-1:0] sw_req,
  input  logic [VEC_W-1:0] ext_stat,
  output logic [IPL_W-1:0] res_ipl,
  output logic [VEC_W-1:0] res_sum
);
  import ipl_pkg::*;

  localparam logic [VEC_W-1:0] SW_MASK = VEC_W'(range_mask(SW_LO, SW_HI));
  localparam logic [VEC_W-1:0] EX_MASK = VEC_W'(range_mask(EX_LO, EX_HI));

  logic [IPL_W-1:0] sw_lvl;
  logic [IPL_W-1:0] ex_lvl;
  logic             ex_any;
  logic             unused_bits;

  // Software levels: index i maps to level (i - SW_LO + 1), highest wins.
  always_comb begin
    sw_lvl = '0;
    for (int i = SW_LO; i < SW_HI; i++)
      if (sw_req[i]) sw_lvl = IPL_W'(i - SW_LO + 1);
  end

  // External levels: index i maps to level i, highest wins.
  always_comb begin
    ex_lvl = '0;
    ex_any = 1'b0;
    for (int i = EX_LO; i < EX_HI; i++)
      if (ext_stat[i]) begin
        ex_lvl = IPL_W'(i);
        ex_any = 1'b1;
      end
  end

  assign res_ipl = ex_any ? ex_lvl : sw_lvl;

  genvar g;
  generate
    for (g = 0; g < VEC_W; g++) begin : g_sum
      if (SW_MASK[g] && EX_MASK[g]) begin : g_both
        assign res_sum[g] = sw_req[g] | ext_stat[g];
      end else if (SW_MASK[g]) begin : g_sw
        assign res_sum[g] = sw_req[g];
      end else if (EX_MASK[g]) begin : g_ex
        assign res_sum[g] = ext_stat[g];
      end else begin : g_none
        assign res_sum[g] = 1'b0;
      end
    end
  endgenerate

  assign unused_bits = ^{sw_req & ~SW_MASK, ext_stat & ~EX_MASK};
endmodule

// File: rtl/ipl_gate.sv
module ipl_gate #(
  parameter int IPL_W = 5,
  parameter int PC_W  = 2
) (
  input  logic [IPL_W-1:0] res_ipl,
  input  logic [IPL_W-1:0] cur_ipl,
  input  logic [PC_W-1:0]  pc_low,
  output logic             irq
);
  logic pc_ok;
  logic lvl_ok;

  assign pc_ok  = (pc_low == '0);
  assign lvl_ok = (res_ipl != '0) && (res_ipl > cur_ipl);
  assign irq    = pc_ok && lvl_ok;
endmodule

// File: rtl/ipl_hold.sv
module ipl_hold #(
  parameter int VEC_W = 32,
  parameter int IPL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             ack,
  input  logic [IPL_W-1:0] res_ipl,
  input  logic [VEC_W-1:0] res_sum,
  output logic             held_vld,
  output logic [IPL_W-1:0] held_ipl,
  output logic [VEC_W-1:0] held_sum,
  output logic [IPL_W-1:0] int_id,
  output logic [VEC_W-1:0] int_sum
);
  logic             commit_en;
  logic             vld_nx;
  logic [IPL_W-1:0] held_ipl_nx;
  logic [VEC_W-1:0] held_sum_nx;
  logic [IPL_W-1:0] int_id_nx;
  logic [VEC_W-1:0] int_sum_nx;

  assign commit_en = ack && held_vld;

  always_comb begin
    vld_nx      = held_vld;
    held_ipl_nx = held_ipl;
    held_sum_nx = held_sum;
    int_id_nx   = int_id;
    int_sum_nx  = int_sum;
    if (commit_en) begin
      int_id_nx  = held_ipl;
      int_sum_nx = held_sum;
    end
    if (ack) vld_nx = 1'b0;
    if (cap_en) begin
      held_ipl_nx = res_ipl;
      held_sum_nx = res_sum;
      vld_nx      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld <= 1'b0;
      held_ipl <= '0;
      held_sum <= '0;
    end else begin
      held_vld <= vld_nx;
      if (cap_en) begin
        held_ipl <= held_ipl_nx;
        held_sum <= held_sum_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_id  <= '0;
      int_sum <= '0;
    end else if (commit_en) begin
      int_id  <= int_id_nx;
      int_sum <= int_sum_nx;
    end
  end
endmodule

// File: rtl/ipl_eval.sv
module ipl_eval #(
  parameter int VEC_W = 32,
  parameter int SW_LO = 1,
  parameter int SW_HI = 16,
  parameter int EX_LO = 16,
  parameter int EX_HI = 32,
  parameter int IPL_W = 5,
  parameter int PC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] sw_req,
  input  logic [VEC_W-1:0] ext_stat,
  input  logic [IPL_W-1:0] cur_ipl,
  input  logic [PC_W-1:0]  pc_low,
  input  logic             take,
  input  logic             ack,
  input  logic             async_trap_req,
  output logic             irq,
  output logic [IPL_W-1:0] int_id,
  output logic [VEC_W-1:0] int_sum,
  output logic             err
);
  logic [IPL_W-1:0] res_ipl;
  logic [VEC_W-1:0] res_sum;
  logic             held_vld;
  logic [IPL_W-1:0] held_ipl;
  logic [VEC_W-1:0] held_sum;
  logic             cap_en;

  ipl_resolve #(
    .VEC_W(VEC_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EX_LO(EX_LO), .EX_HI(EX_HI), .IPL_W(IPL_W)
  ) u_resolve (
    .sw_req  (sw_req),
    .ext_stat(ext_stat),
    .res_ipl (res_ipl),
    .res_sum (res_sum)
  );

  ipl_gate #(.IPL_W(IPL_W), .PC_W(PC_W)) u_gate (
    .res_ipl(res_ipl),
    .cur_ipl(cur_ipl),
    .pc_low (pc_low),
    .irq    (irq)
  );

  assign cap_en = take && irq;

  ipl_hold #(.VEC_W(VEC_W), .IPL_W(IPL_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .ack     (ack),
    .res_ipl (res_ipl),
    .res_sum (res_sum),
    .held_vld(held_vld),
    .held_ipl(held_ipl),
    .held_sum(held_sum),
    .int_id  (int_id),
    .int_sum (int_sum)
  );

  assign err = (ack && !held_vld) || async_trap_req;
endmodule

// File: rtl/ipl_eval_chk.sv
module ipl_eval_chk #(
  parameter int VEC_W = 32,
  parameter int IPL_W = 5,
  parameter int PC_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [PC_W-1:0]  pc_low,
  input logic [IPL_W-1:0] res_ipl,
  input logic [IPL_W-1:0] cur_ipl,
  input logic             take,
  input logic             ack,
  input logic             async_trap_req,
  input logic             held_vld,
  input logic [IPL_W-1:0] held_ipl,
  input logic [VEC_W-1:0] held_sum,
  input logic [IPL_W-1:0] int_id,
  input logic [VEC_W-1:0] int_sum,
  input logic             err
);
  // R6
  pc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_low != '0) |-> !irq);

  // R5
  lvl_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (res_ipl > cur_ipl));

  // R8
  commit_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && held_vld) |=> (int_id == $past(held_ipl)) && (int_sum == $past(held_sum)));

  // R8
  vld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(take && irq)) |=> !held_vld);

  // R7
  regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ($stable(int_id) && $stable(int_sum)));

  // R9
  ack_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !held_vld) |-> err);

  // R10
  trap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_trap_req |-> err);

  // R12
  no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_vld && !(take && irq)) |=> !held_vld);
endmodule

bind ipl_eval ipl_eval_chk #(.VEC_W(VEC_W), .IPL_W(IPL_W), .PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq           (irq),
  .pc_low        (pc_low),
  .res_ipl       (res_ipl),
  .cur_ipl       (cur_ipl),
  .take          (take),
  .ack           (ack),
  .async_trap_req(async_trap_req),
  .held_vld      (held_vld),
  .held_ipl      (held_ipl),
  .held_sum      (held_sum),
  .int_id        (int_id),
  .int_sum       (int_sum),
  .err           (err)
);

// File: tb/ipl_eval_bench.sv
module ipl_eval_bench;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] sw_req;
  logic [31:0] ext_stat;
  logic [4:0]  cur_ipl;
  logic [1:0]  pc_low;
  logic        take;
  logic        ack;
  logic        async_trap_req;
  logic        irq;
  logic [4:0]  int_id;
  logic [31:0] int_sum;
  logic        err;

  int total;
  int bad;
  bit done;

  // reference model state
  int          m_id;
  logic [31:0] m_sum;
  bit          m_vld;
  int          m_hid;
  logic [31:0] m_hsum;

  ipl_eval u_ipl_eval (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_stat(ext_stat),
    .cur_ipl(cur_ipl), .pc_low(pc_low), .take(take), .ack(ack),
    .async_trap_req(async_trap_req), .irq(irq), .int_id(int_id),
    .int_sum(int_sum), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: level and mask from the two vectors
  function automatic int ref_lvl(input logic [31:0] s, input logic [31:0] e);
    int lvl = 0;
    for (int i = 1; i <= 15; i++) if (s[i]) lvl = i;
    for (int i = 16; i <= 31; i++) if (e[i]) lvl = i;
    return lvl;
  endfunction

  function automatic logic [31:0] ref_sum(input logic [31:0] s, input logic [31:0] e);
    logic [31:0] m = '0;
    for (int i = 1; i <= 15; i++) if (s[i]) m[i] = 1'b1;
    for (int i = 16; i <= 31; i++) if (e[i]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic step(input logic [31:0] s, input logic [31:0] e, input int c,
                      input logic [1:0] p, input bit t, input bit a, input bit tr,
                      input string req);
    int lvl;
    bit exp_irq;
    bit exp_err;
    logic [31:0] sm;
    sw_req = s; ext_stat = e; cur_ipl = 5'(c); pc_low = p;
    take = t; ack = a; async_trap_req = tr;
    #1;
    lvl     = ref_lvl(s, e);
    sm      = ref_sum(s, e);
    exp_irq = (p == 2'b00) && (lvl != 0) && (lvl > c);
    exp_err = (a && !m_vld) || tr;
    chk(req, "irq", {31'd0, irq}, {31'd0, exp_irq});
    chk(req, "err", {31'd0, err}, {31'd0, exp_err});
    chk(req, "int_id", {27'd0, int_id}, 32'(m_id));
    chk(req, "int_sum", int_sum, m_sum);
    @(posedge clk);
    if (a && m_vld) begin
      m_id  = m_hid;
      m_sum = m_hsum;
    end
    if (a) m_vld = 0;
    if (t && exp_irq) begin
      m_hid  = lvl;
      m_hsum = sm;
      m_vld  = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    m_id = 0; m_sum = '0; m_vld = 0; m_hid = 0; m_hsum = '0;
    rst_n = 1'b0;
    sw_req = '0; ext_stat = '0; cur_ipl = '0; pc_low = '0;
    take = 0; ack = 0; async_trap_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then ack with nothing held flags error (R9)
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R1");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R1");
    // R2: software bits 3, 7 and ignored bit 0; level 7, mask drops bit 0 (R4)
    step(32'h0000_0089, 32'h0, 0, 2'b00, 1, 0, 0, "R2");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R4");
    // R2: bits above the software range in sw_req are ignored
    step(32'hFFFF_0001, 32'h0, 0, 2'b00, 0, 0, 0, "R2");
    // R5: equal level gives no request; one below gives a request
    step(32'h0000_0080, 32'h0, 7, 2'b00, 0, 0, 0, "R5");
    step(32'h0000_0080, 32'h0, 6, 2'b00, 0, 0, 0, "R5");
    step(32'h0000_8000, 32'h0, 15, 2'b00, 0, 0, 0, "R5");
    // R3: external line 20 overrides software bit 15; low ext bits ignored
    step(32'h0000_8000, 32'h0010_FFFF, 19, 2'b00, 1, 0, 0, "R3");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R3");
    step(32'h0, 32'h0000_FFFF, 0, 2'b00, 0, 0, 0, "R3");
    // R6: misaligned PC suppresses the request
    step(32'h0, 32'h8000_0000, 0, 2'b01, 0, 0, 0, "R6");
    step(32'h0, 32'h8000_0000, 0, 2'b10, 0, 0, 0, "R6");
    step(32'h0, 32'h8000_0000, 0, 2'b11, 0, 0, 0, "R6");
    // R12: take while irq low captures nothing; later ack errors, regs hold
    step(32'h0000_0004, 32'h0, 0, 2'b01, 1, 0, 0, "R12");
    step(32'h0000_0004, 32'h0, 5, 2'b00, 1, 0, 0, "R12");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R12");
    // R7: after take, registers stay until ack
    step(32'h0000_0010, 32'h0, 0, 2'b00, 1, 0, 0, "R7");
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R7");
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R7");
    // R11: take new (ext 25) and ack old (level 4) in the same cycle
    step(32'h0, 32'h0200_0000, 0, 2'b00, 1, 1, 0, "R11");
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R11");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R11");
    // R8: second ack errors and leaves registers unchanged
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R8");
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R8");
    // R9: ack with nothing held plus a valid take in the same cycle
    step(32'h0000_0002, 32'h0, 0, 2'b00, 1, 1, 0, "R9");
    step(32'h0, 32'h0, 0, 2'b00, 0, 1, 0, "R9");
    // R10: asynchronous trap request flags error
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 1, "R10");
    step(32'h0000_0100, 32'h0, 0, 2'b00, 0, 0, 1, "R10");
    // R4: all bits set, tie at top level 31, full mask except bit 0
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 30, 2'b00, 1, 0, 0, "R4");
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 31, 2'b00, 0, 1, 0, "R4");
    step(32'h0, 32'h0, 0, 2'b00, 0, 0, 0, "R4");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule